// File: doc/BRIEF.md
# Lane-Point Allocation Filter

This block turns a raster stream of per-pixel peak flags into a lane map that is one pixel wide. Each frame row has a fixed number of columns, 64 by default. For every accepted pixel the block outputs one lane bit. An upstream peak detector delivers one flag per pixel clock, together with its row and column index. The lane map goes on to later stages, such as curve fitting, which are not part of this block.

Two functions run in series. The first is a segment filter. It keeps a peak only when the row just completed also held a peak within three columns to either side. The second is a run thinner. When several supported peaks sit side by side in one row, it keeps only the leftmost of them. Each result leaves the block a fixed number of clocks after its pixel entered. The valid flag and the row and column indices travel with it.

Top module: `lane_point_alloc`

## Requirements
- R1: While reset is asserted, and from the moment it is asserted, `out_valid` and `out_lane` are 0.
- R2: An input pixel presented with `in_valid` high appears on the outputs exactly 4 clocks later, with `out_row` and `out_col` equal to its input indices.
- R3: `out_lane` is 1 only for a pixel whose own peak flag was 1.
- R4: Pixels of row index 0 never produce a lane point, whatever the earlier rows held.
- R5: A peak at column c is supported when the previous row had a peak in some column from c-3 to c+3. Unsupported peaks give `out_lane` 0.
- R6: Window columns below 0 or above 63 count as having no peak.
- R7: Among supported peaks in adjacent columns of one row, only the leftmost gives `out_lane` 1. A supported peak at column 0 always counts as leftmost.
- R8: A clock with `in_valid` low gives `out_valid` 0 four clocks later. Such gaps leave the results of the surrounding pixels unchanged.
- R9: The support window reads the row received most recently in full (its last column is 63), and no row before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in sync with clk |
| in_valid | input | 1 | Pixel present this clock |
| in_peak | input | 1 | Peak flag of the pixel |
| in_row | input | 6 | Row index, 0 at frame start |
| in_col | input | 6 | Column index, 0 to 63 in order |
| out_valid | output | 1 | Delayed pixel-present flag |
| out_lane | output | 1 | Lane-point bit for the delayed pixel |
| out_row | output | 6 | Row index of the delayed pixel |
| out_col | output | 6 | Column index of the delayed pixel |

## Verification
The bench targets the window edges at columns 0 and 63. A design that wrapped or read past the row would find support it should not find. It also checks the first row of each new frame, where leftover data from the last frame would leak into the output. Wide runs of peaks and alternating peaks are used as well: a wrong thinner would either mark every pixel of a run or drop isolated points. Clocks with no pixel are inserted mid-row to catch a thinner that loses its left neighbour across a gap, or a latency that slips. One row sits between an empty row and an earlier busy row. This catches a design that reads stale history rather than the last complete row.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
  localparam int unsigned LPA_COLS     = 64;
  localparam int unsigned LPA_ROWS     = 64;
  localparam int unsigned LPA_HALF_WIN = 3;
  localparam int unsigned LPA_LATENCY  = 4;
endpackage

// File: rtl/lpa_seg_filter.sv
module lpa_seg_filter #(
  parameter int unsigned COLS     = lpa_pkg::LPA_COLS,
  parameter int unsigned ROWS     = lpa_pkg::LPA_ROWS,
  parameter int unsigned HALF_WIN = lpa_pkg::LPA_HALF_WIN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    px_valid,
  input  logic                    px_peak,
  input  logic [$clog2(ROWS)-1:0] px_row,
  input  logic [$clog2(COLS)-1:0] px_col,
  output logic                    supported
);
  localparam int unsigned CW  = $clog2(COLS);
  localparam int unsigned WIN = 2 * HALF_WIN + 1;
  localparam int unsigned PW  = COLS + 2 * HALF_WIN;

  logic [COLS-1:0] above_q, above_d;
  logic [COLS-1:0] build_q, build_d;
  logic [PW-1:0]   padded;
  logic [WIN-1:0]  window;

  // Pad with zeros so edge windows see empty columns.
  assign padded = {{HALF_WIN{1'b0}}, above_q, {HALF_WIN{1'b0}}};
  assign window = padded[px_col +: WIN];

  always_comb begin
    build_d = build_q;
    above_d = above_q;
    if (px_valid) begin
      build_d[px_col] = px_peak;
      if (px_col == CW'(COLS - 1)) begin
        above_d = build_d;
      end
    end
  end

  assign supported = px_valid && px_peak && (px_row != '0) && (|window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= '0;
      build_q <= '0;
    end else if (px_valid) begin
      above_q <= above_d;
      build_q <= build_d;
    end
  end
endmodule

// File: rtl/lpa_run_thin.sv
module lpa_run_thin #(
  parameter int unsigned COLS = lpa_pkg::LPA_COLS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    px_valid,
  input  logic [$clog2(COLS)-1:0] px_col,
  input  logic                    supported,
  output logic                    lane
);
  logic left_q, left_d;
  logic left_live;

  // Left neighbour only counts inside the same row.
  assign left_live = left_q && (px_col != '0);
  assign lane      = supported && !left_live;

  always_comb begin
    left_d = left_q;
    if (px_valid) begin
      left_d = supported;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= 1'b0;
    end else if (px_valid) begin
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/lpa_delay.sv
module lpa_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = lpa_pkg::LPA_LATENCY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [DEPTH:0][WIDTH-1:0] tap;

  assign tap[0] = din;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [WIDTH-1:0] stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else begin
        stage_q <= tap[s];
      end
    end
    assign tap[s+1] = stage_q;
  end

  assign dout = tap[DEPTH];
endmodule

// File: rtl/lane_point_alloc.sv
module lane_point_alloc #(
  parameter int unsigned COLS     = lpa_pkg::LPA_COLS,
  parameter int unsigned ROWS     = lpa_pkg::LPA_ROWS,
  parameter int unsigned HALF_WIN = lpa_pkg::LPA_HALF_WIN,
  parameter int unsigned LATENCY  = lpa_pkg::LPA_LATENCY
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_peak,
  input  logic [$clog2(ROWS)-1:0] in_row,
  input  logic [$clog2(COLS)-1:0] in_col,
  output logic                    out_valid,
  output logic                    out_lane,
  output logic [$clog2(ROWS)-1:0] out_row,
  output logic [$clog2(COLS)-1:0] out_col
);
  localparam int unsigned CW = $clog2(COLS);
  localparam int unsigned RW = $clog2(ROWS);
  localparam int unsigned PW = 2 + RW + CW;

  logic          seg_sup;
  logic          lane_raw;
  logic [PW-1:0] pay_in, pay_out;

  lpa_seg_filter #(.COLS(COLS), .ROWS(ROWS), .HALF_WIN(HALF_WIN)) seg_i (
    .clk(clk), .rst_n(rst_n), .px_valid(in_valid), .px_peak(in_peak),
    .px_row(in_row), .px_col(in_col), .supported(seg_sup)
  );

  lpa_run_thin #(.COLS(COLS)) thin_i (
    .clk(clk), .rst_n(rst_n), .px_valid(in_valid), .px_col(in_col),
    .supported(seg_sup), .lane(lane_raw)
  );

  assign pay_in = {in_valid, lane_raw, in_row, in_col};

  lpa_delay #(.WIDTH(PW), .DEPTH(LATENCY)) dly_i (
    .clk(clk), .rst_n(rst_n), .din(pay_in), .dout(pay_out)
  );

  assign {out_valid, out_lane, out_row, out_col} = pay_out;
endmodule

// File: rtl/lpa_checker.sv
module lpa_checker #(
  parameter int unsigned CW = 6,
  parameter int unsigned RW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_peak,
  input logic          seg_sup,
  input logic          lane_raw,
  input logic          out_valid,
  input logic          out_lane,
  input logic [RW-1:0] out_row,
  input logic [CW-1:0] out_col
);
  // R3: thinner marks only where the filter saw a real peak
  a_r3_lane_has_peak: assert property (@(posedge clk) disable iff (!rst_n)
    lane_raw |-> (in_valid && in_peak && seg_sup));

  // R4: first row of a frame is never marked
  a_r4_first_row_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_row == '0) |-> !out_lane);

  // R7: no two marked pixels side by side in one row
  a_r7_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_lane && $past(out_valid) && $past(out_lane)
     && out_row == $past(out_row)) |-> ((out_col - $past(out_col)) != CW'(1)));

  // R8: a lane bit never appears without a valid pixel
  a_r8_lane_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_lane |-> out_valid);

  // R1: outputs quiet right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_lane));
endmodule

bind lane_point_alloc lpa_checker #(.CW($clog2(COLS)), .RW($clog2(ROWS))) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_peak(in_peak),
  .seg_sup(seg_sup), .lane_raw(lane_raw), .out_valid(out_valid),
  .out_lane(out_lane), .out_row(out_row), .out_col(out_col)
);

// File: tb/lane_point_alloc_tb_top.sv
module lane_point_alloc_tb_top;
  localparam int LAT  = 4;
  localparam int NROW = 8;
  localparam int HIST = 4096;
  localparam logic [63:0] B = 64'd1;

  // Stimulus table: one peak row per entry, bit c = column c
  localparam logic [63:0] ROW_PAT [NROW] = '{
    (B << 10) | (B << 11) | (B << 12) | (B << 63),
    (B << 13) | (B << 20) | (B << 0) | (B << 1) | (B << 2) | (B << 60),
    (B << 3) | (B << 4) | (B << 5) | (B << 63) | (B << 16) | (B << 17),
    (B << 0) | (B << 7) | (B << 9) | (B << 56) | (B << 57),
    64'h0,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h5555_5555_5555_5555
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_peak = 1'b0;
  logic [5:0] in_row = '0, in_col = '0;
  logic       out_valid, out_lane;
  logic [5:0] out_row, out_col;

  int    cyc = 0, n_tests = 0, n_fail = 0;
  logic  mon_en = 1'b0;
  logic  ev [HIST];
  logic  el [HIST];
  logic [5:0] er [HIST];
  logic [5:0] ec [HIST];
  string et [HIST];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lane_point_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_peak(in_peak),
    .in_row(in_row), .in_col(in_col), .out_valid(out_valid),
    .out_lane(out_lane), .out_row(out_row), .out_col(out_col)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit sup_f(logic [63:0] pv, logic [63:0] cu, int r, int c);
    if (r == 0 || !cu[c]) return 1'b0;
    for (int k = c - 3; k <= c + 3; k++)
      if (k >= 0 && k < 64 && pv[k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic drive(input logic v, input logic p, input int r, input int c,
                       input logic lane, input string tag);
    @(posedge clk);
    #2;
    in_valid = v; in_peak = p; in_row = 6'(r); in_col = 6'(c);
    ev[cyc % HIST] = v; el[cyc % HIST] = lane;
    er[cyc % HIST] = 6'(r); ec[cyc % HIST] = 6'(c); et[cyc % HIST] = tag;
  endtask

  // Output monitor: compares against the entry driven LAT clocks earlier
  always @(negedge clk) begin
    if (mon_en && cyc >= LAT) begin
      automatic int k = (cyc - LAT) % HIST;
      check(out_valid == ev[k], ev[k] ? "R2" : "R8", out_valid, ev[k]);
      if (ev[k] && out_valid) begin
        check(out_row == er[k] && out_col == ec[k], "R2",
              {out_row, out_col}, {er[k], ec[k]});
        check(out_lane == el[k], et[k], out_lane, el[k]);
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < HIST; i++) begin
      ev[i] = 1'b0; el[i] = 1'b0; er[i] = '0; ec[i] = '0; et[i] = "R8";
    end
    repeat (3) @(posedge clk);
    #5;
    check(out_valid == 1'b0 && out_lane == 1'b0, "R1", {out_valid, out_lane}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // Table walk: two frames, the second with idle clocks mid-row
    for (int pass = 0; pass < 2; pass++) begin
      for (int r = 0; r < NROW; r++) begin
        for (int c = 0; c < 64; c++) begin
          automatic logic [63:0] pv = (r == 0) ? 64'h0 : ROW_PAT[r-1];
          automatic logic [63:0] cu = ROW_PAT[r];
          automatic bit s   = sup_f(pv, cu, r, c);
          automatic bit sl  = (c > 0) ? sup_f(pv, cu, r, c - 1) : 1'b0;
          automatic string tag;
          if (r == 0)            tag = "R4";
          else if (!cu[c])       tag = "R3";
          else if (s && sl)      tag = "R7";
          else if (r == 5)       tag = "R9";
          else if (c < 3 || c > 60) tag = "R6";
          else                   tag = "R5";
          if (pass == 1 && (c % 5) == 2) drive(1'b0, 1'b1, r, c, 1'b0, "R8");
          drive(1'b1, cu[c], r, c, s && !sl, tag);
        end
      end
    end
    repeat (LAT + 2) drive(1'b0, 1'b0, 0, 0, 1'b0, "R8");
    mon_en = 1'b0;

    // Reset asserted mid-stream clears outputs at once
    drive(1'b1, 1'b1, 3, 5, 1'b0, "R1");
    drive(1'b1, 1'b1, 3, 6, 1'b0, "R1");
    repeat (LAT - 1) @(posedge clk);
    #5;
    check(out_valid == 1'b1, "R2", out_valid, 1);
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0 && out_lane == 1'b0, "R1", {out_valid, out_lane}, 0);
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    check(out_valid == 1'b0, "R1", out_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule